// File: doc/BRIEF.md
# RTC Two-Wire Command Interface

This block is the serial slave front end of a clock/calendar core. A fast system clock oversamples the two bus lines, SCL and SDA. The block finds start and stop conditions and decodes the first byte after each start. That byte carries a fixed device code, a 3-bit command and a direction bit. The block has no register address pointer. The command alone picks a fixed-length burst of register bytes, and every data byte on the bus travels least significant bit first.

The core behind the block sees strobes for each byte. A write strobe presents each received byte with its burst index. A read strobe asks for the byte at an index, and the core answers on a byte input. A command strobe reports every accepted command, including reset and the test-mode commands, which carry no data. For the two time-setting commands, a hold level keeps the calendar counters stopped while the new values arrive. A one-cycle restart pulse then lets the counters run again. The bus pin is driven open-drain: the block only ever pulls SDA low.

Top module: `rtcw_cmd_if`

## Requirements
- R1: The first byte after a start is taken MSB first. Bits 7:4 must equal 0110, bits 3:1 form the command and bit 0 is the direction (1 = read). A matching byte is acknowledged by holding SDA low through the ninth SCL clock, and `cmd_stb_o` pulses once with the command on `cmd_o`. SDA is only ever pulled low after a falling SCL edge.
- R2: A first byte whose bits 7:4 differ from 0110 is not acknowledged. It produces no strobe, and every following byte is ignored without acknowledge until the next start.
- R3: On a write, each data byte is taken LSB first. It is acknowledged and presented on `wr_data_o` with a one-cycle `wr_stb_o`, and `idx_o` gives its position in the burst, starting at 0.
- R4: The burst length follows the command: 001 moves 1 byte, 010 moves 7, 011 moves 3, and 100 and 101 move 2 each. A byte beyond that count is neither acknowledged nor strobed.
- R5: On a read of 001, 010 or 011, `rd_stb_o` pulses once per byte with the index on `idx_o`. The byte on `rd_data_i` is then sent LSB first, its first bit on SDA before the SCL rise that follows the preceding acknowledge.
- R6: A read ends when the master does not acknowledge, or after the last byte of the burst. SDA is then released. A stop condition in the middle of a read aborts it and returns the block to idle, ready for the next start.
- R7: Commands 000 (reset), 110 and 111 (test mode on and off) are acknowledged and carry no data bytes, whatever the direction bit. Following bytes are not acknowledged, and SDA is not driven.
- R8: A write of command 010 or 011 raises `hold_o` at the acknowledge of the command byte. `hold_o` drops at the acknowledge of the final byte of the burst, together with a one-cycle `restart_o` pulse.
- R9: A start or stop condition while `hold_o` is high drops `hold_o` and pulses `restart_o` once.
- R10: A read of 100 or 101 (write-only registers) is acknowledged, but SDA stays released, so the master reads 0xFF bytes. `rd_stb_o` does not pulse.
- R11: After reset, `sda_oe_o`, `hold_o` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| rd_data_i | input | 8 | Read byte from the core; valid from the cycle after `rd_stb_o` |
| cmd_o | output | 3 | Current command |
| idx_o | output | 3 | Byte index within the burst |
| cmd_stb_o | output | 1 | One-cycle pulse per accepted command byte |
| rd_stb_o | output | 1 | One-cycle request for byte `idx_o` |
| wr_stb_o | output | 1 | One-cycle pulse with a received byte |
| wr_data_o | output | 8 | Received byte |
| hold_o | output | 1 | Calendar counter hold during a time write |
| restart_o | output | 1 | One-cycle pulse releasing the counters |

## Verification
A wrong phase or bit count in this block shows up on SDA within one byte time. The acknowledge slot comes out high, or read bits appear shifted, and the master's ninth-clock sample catches it. A wrong index or burst length shows at the core interface within one strobe: a missing or extra `wr_stb_o`/`rd_stb_o`, or the wrong `idx_o`, comes out alongside the byte concerned. Hold errors are visible at the two acknowledges that bracket a time write, or immediately after a stop that cuts one short.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 3;
  localparam int IDX_W  = 3;
  localparam int BCNT_W = $clog2(BYTE_W + 1);
  localparam logic [3:0] DEV_CODE = 4'b0110;

  localparam logic [CMD_W-1:0] CMD_RESET    = 3'd0;
  localparam logic [CMD_W-1:0] CMD_STATUS   = 3'd1;
  localparam logic [CMD_W-1:0] CMD_TIME_ALL = 3'd2;
  localparam logic [CMD_W-1:0] CMD_TIME_HMS = 3'd3;
  localparam logic [CMD_W-1:0] CMD_ALM_A    = 3'd4;
  localparam logic [CMD_W-1:0] CMD_ALM_B    = 3'd5;

  typedef enum logic [3:0] {
    PH_IDLE, PH_HDR, PH_ACK_PREP, PH_ACK, PH_WR,
    PH_RD, PH_RD_ACK, PH_RD_NEXT, PH_SKIP
  } phase_e;

  function automatic logic [IDX_W-1:0] burst_len(input logic [CMD_W-1:0] c);
    case (c)
      CMD_STATUS:          burst_len = 3'd1;
      CMD_TIME_ALL:        burst_len = 3'd7;
      CMD_TIME_HMS:        burst_len = 3'd3;
      CMD_ALM_A, CMD_ALM_B: burst_len = 3'd2;
      default:             burst_len = 3'd0;
    endcase
  endfunction

  function automatic logic is_readable(input logic [CMD_W-1:0] c);
    is_readable = (c == CMD_STATUS) || (c == CMD_TIME_ALL) || (c == CMD_TIME_HMS);
  endfunction

  function automatic logic holds_counter(input logic [CMD_W-1:0] c);
    holds_counter = (c == CMD_TIME_ALL) || (c == CMD_TIME_HMS);
  endfunction
endpackage

// File: rtl/rtcw_bus_sync.sv
module rtcw_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_s, scl_d, sda_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      logic scl_q, sda_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= 1'b1;
          sda_q <= 1'b1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
      assign scl_s = scl_q;
      assign sda_s = sda_q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] scl_q, sda_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
          sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
        end
      end
      assign scl_s = scl_q[SYNC_STAGES-1];
      assign sda_s = sda_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/rtcw_xfer_ctrl.sv
module rtcw_xfer_ctrl
  import rtcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              cmd_stb_o,
  output logic              rd_stb_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              hold_o,
  output logic              restart_o
);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W - 1);
  localparam logic [BCNT_W-1:0] ALL_BITS = BCNT_W'(BYTE_W);

  phase_e              ph, ph_n;
  logic [BCNT_W-1:0]   bcnt, bcnt_n;
  logic [BYTE_W-2:0]   shreg, shreg_n;
  logic [BYTE_W-1:0]   tx, tx_n, txv;
  logic [CMD_W-1:0]    cmd, cmd_n;
  logic                rw, rw_n, from_hdr, from_hdr_n;
  logic [IDX_W-1:0]    idx, idx_n, len, len_m1;
  logic                oe, oe_n, hold, hold_n, rst_p, rst_p_n;
  logic                cstb_n, rstb_n, wstb_n, cstb, rstb, wstb;
  logic [BYTE_W-1:0]   wdat, wdat_n;
  logic                last;

  assign len    = burst_len(cmd);
  assign len_m1 = len - 3'd1;
  assign last   = (idx == len_m1);
  assign txv    = is_readable(cmd) ? rd_data_i : '1;

  always_comb begin
    ph_n = ph; bcnt_n = bcnt; shreg_n = shreg; tx_n = tx;
    cmd_n = cmd; rw_n = rw; from_hdr_n = from_hdr; idx_n = idx;
    oe_n = oe; hold_n = hold; wdat_n = wdat;
    rst_p_n = 1'b0; cstb_n = 1'b0; rstb_n = 1'b0; wstb_n = 1'b0;
    if (start_det || stop_det) begin
      ph_n   = start_det ? PH_HDR : PH_IDLE;
      bcnt_n = '0;
      idx_n  = '0;
      oe_n   = 1'b0;
      if (hold) begin
        hold_n  = 1'b0;
        rst_p_n = 1'b1;
      end
    end else begin
      case (ph)
        PH_HDR: if (scl_rise) begin
          shreg_n = {shreg[BYTE_W-3:0], sda_s};
          bcnt_n  = bcnt + 1'b1;
          if (bcnt == LAST_BIT) begin
            if (shreg[BYTE_W-2:BYTE_W-5] == DEV_CODE) begin
              cmd_n      = shreg[CMD_W-1:0];
              rw_n       = sda_s;
              from_hdr_n = 1'b1;
              ph_n       = PH_ACK_PREP;
            end else begin
              ph_n = PH_SKIP;
            end
          end
        end
        PH_WR: if (scl_rise) begin
          bcnt_n = bcnt + 1'b1;
          if (bcnt == LAST_BIT) begin
            wdat_n     = {sda_s, shreg};
            wstb_n     = 1'b1;
            from_hdr_n = 1'b0;
            ph_n       = PH_ACK_PREP;
          end else begin
            shreg_n[bcnt[2:0]] = sda_s;
          end
        end
        PH_ACK_PREP: if (scl_fall) begin
          oe_n = 1'b1;
          ph_n = PH_ACK;
          if (from_hdr) begin
            cstb_n = 1'b1;
            if (!rw && holds_counter(cmd)) hold_n = 1'b1;
            if (rw && is_readable(cmd))    rstb_n = 1'b1;
          end else if (last && hold) begin
            hold_n  = 1'b0;
            rst_p_n = 1'b1;
          end
        end
        PH_ACK: if (scl_fall) begin
          oe_n   = 1'b0;
          bcnt_n = '0;
          if (from_hdr) begin
            if (len == '0) begin
              ph_n = PH_SKIP;
            end else if (rw) begin
              tx_n = txv;
              oe_n = ~txv[0];
              ph_n = PH_RD;
            end else begin
              ph_n = PH_WR;
            end
          end else if (last) begin
            ph_n = PH_SKIP;
          end else begin
            idx_n = idx + 3'd1;
            ph_n  = PH_WR;
          end
        end
        PH_RD: begin
          if (scl_rise) bcnt_n = bcnt + 1'b1;
          if (scl_fall) begin
            if (bcnt == ALL_BITS) begin
              oe_n = 1'b0;
              ph_n = PH_RD_ACK;
            end else begin
              oe_n = ~tx[bcnt[2:0]];
            end
          end
        end
        PH_RD_ACK: if (scl_rise) begin
          if (sda_s || last) begin
            ph_n = PH_SKIP;
          end else begin
            idx_n  = idx + 3'd1;
            rstb_n = is_readable(cmd);
            ph_n   = PH_RD_NEXT;
          end
        end
        PH_RD_NEXT: if (scl_fall) begin
          tx_n   = txv;
          oe_n   = ~txv[0];
          bcnt_n = '0;
          ph_n   = PH_RD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; bcnt <= '0; shreg <= '0; tx <= '1;
      cmd <= '0; rw <= 1'b0; from_hdr <= 1'b0; idx <= '0;
      oe <= 1'b0; hold <= 1'b0; rst_p <= 1'b0; wdat <= '0;
      cstb <= 1'b0; rstb <= 1'b0; wstb <= 1'b0;
    end else begin
      ph <= ph_n; bcnt <= bcnt_n; shreg <= shreg_n; tx <= tx_n;
      cmd <= cmd_n; rw <= rw_n; from_hdr <= from_hdr_n; idx <= idx_n;
      oe <= oe_n; hold <= hold_n; rst_p <= rst_p_n; wdat <= wdat_n;
      cstb <= cstb_n; rstb <= rstb_n; wstb <= wstb_n;
    end
  end

  assign sda_oe_o  = oe;
  assign cmd_o     = cmd;
  assign idx_o     = idx;
  assign cmd_stb_o = cstb;
  assign rd_stb_o  = rstb;
  assign wr_stb_o  = wstb;
  assign wr_data_o = wdat;
  assign hold_o    = hold;
  assign restart_o = rst_p;
endmodule

// File: rtl/rtcw_cmd_if.sv
module rtcw_cmd_if
  import rtcw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              cmd_stb_o,
  output logic              rd_stb_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              hold_o,
  output logic              restart_o
);
  logic rst_meta, rst_sync_n;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  rtcw_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  rtcw_xfer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data_i(rd_data_i), .sda_oe_o(sda_oe_o), .cmd_o(cmd_o),
    .idx_o(idx_o), .cmd_stb_o(cmd_stb_o), .rd_stb_o(rd_stb_o),
    .wr_stb_o(wr_stb_o), .wr_data_o(wr_data_o),
    .hold_o(hold_o), .restart_o(restart_o)
  );
endmodule

// File: rtl/rtcw_cmd_if_chk.sv
module rtcw_cmd_if_chk
  import rtcw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scl_fall,
  input logic             sda_oe_o,
  input logic [CMD_W-1:0] cmd_o,
  input logic [IDX_W-1:0] idx_o,
  input logic             cmd_stb_o,
  input logic             rd_stb_o,
  input logic             wr_stb_o,
  input logic             hold_o,
  input logic             restart_o
);
  // R1
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(scl_fall));

  // R7
  cmd_stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb_o |=> !cmd_stb_o);

  // R3
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb_o && rd_stb_o));

  // R4
  wr_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (idx_o < burst_len(cmd_o)));

  // R5
  rd_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_o |-> (idx_o < burst_len(cmd_o)));

  // R10
  rd_cmd_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_o |-> is_readable(cmd_o));

  // R8
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> holds_counter(cmd_o));

  // R8
  restart_follows_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> (!hold_o && $past(hold_o)));

  // R9
  restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o);
endmodule

bind rtcw_cmd_if rtcw_cmd_if_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .scl_fall(scl_fall), .sda_oe_o(sda_oe_o),
  .cmd_o(cmd_o), .idx_o(idx_o), .cmd_stb_o(cmd_stb_o), .rd_stb_o(rd_stb_o),
  .wr_stb_o(wr_stb_o), .hold_o(hold_o), .restart_o(restart_o)
);

// File: tb/rtcw_cmd_if_tb.sv
module rtcw_cmd_if_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic sda_oe_o, cmd_stb_o, rd_stb_o, wr_stb_o, hold_o, restart_o;
  logic [2:0] cmd_o, idx_o;
  logic [7:0] wr_data_o, rd_data_i;

  int nchk = 0, nerr = 0;
  int wr_cnt = 0, rd_cnt = 0, cmd_cnt = 0, rs_cnt = 0;
  logic [7:0] wr_log [0:31];
  logic [2:0] wr_idx_log [0:31];
  logic [2:0] last_cmd;
  bit done = 0;

  always #5 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe_o;
  assign rd_data_i = {cmd_o, 2'b10, idx_o};

  rtcw_cmd_if u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .rd_data_i(rd_data_i), .cmd_o(cmd_o), .idx_o(idx_o),
    .cmd_stb_o(cmd_stb_o), .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o),
    .wr_data_o(wr_data_o), .hold_o(hold_o), .restart_o(restart_o)
  );

  always @(negedge clk) begin
    if (wr_stb_o) begin
      wr_log[wr_cnt[4:0]] = wr_data_o;
      wr_idx_log[wr_cnt[4:0]] = idx_o;
      wr_cnt++;
    end
    if (rd_stb_o) rd_cnt++;
    if (cmd_stb_o) begin cmd_cnt++; last_cmd = cmd_o; end
    if (restart_o) rs_cnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bstart;
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bstop;
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(2*Q);
  endtask

  task automatic put_bit(input bit b);
    tick(Q); sda_m = b; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0;
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1; tick(2*Q); scl_m = 1; tick(Q); b = sda_line; tick(Q); scl_m = 0;
  endtask

  task automatic send_byte(input logic [7:0] v, input bit lsb_first, output bit acked);
    bit l;
    for (int i = 0; i < 8; i++) put_bit(lsb_first ? v[i] : v[7-i]);
    get_bit(l);
    acked = !l;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit master_ack);
    bit b;
    for (int i = 0; i < 8; i++) begin get_bit(b); v[i] = b; end
    put_bit(!master_ack);
  endtask

  function automatic logic [7:0] hdr(input logic [2:0] c, input bit rd);
    return {4'b0110, c, rd};
  endfunction

  task automatic t_reset_state;
    chk(sda_oe_o == 0 && hold_o == 0, "R11 oe/hold after reset", {sda_oe_o, hold_o}, 0);
    chk(wr_cnt + rd_cnt + cmd_cnt + rs_cnt == 0, "R11 no strobes after reset",
        wr_cnt + rd_cnt + cmd_cnt + rs_cnt, 0);
  endtask

  task automatic t_status_write;
    bit a; int w0 = wr_cnt, c0 = cmd_cnt;
    bstart;
    send_byte(hdr(3'd1, 0), 0, a);
    chk(a, "R1 header ack", a, 1);
    chk(cmd_cnt == c0 + 1 && last_cmd == 3'd1, "R1 cmd strobe", last_cmd, 1);
    send_byte(8'hA5, 1, a);
    chk(a, "R3 data ack", a, 1);
    chk(wr_log[w0[4:0]] == 8'hA5 && wr_idx_log[w0[4:0]] == 0, "R3 LSB-first byte",
        wr_log[w0[4:0]], 8'hA5);
    send_byte(8'h3C, 1, a);
    chk(!a && wr_cnt == w0 + 1, "R4 extra status byte ignored", wr_cnt - w0, 1);
    bstop;
  endtask

  task automatic t_bad_code;
    bit a; int w0 = wr_cnt, c0 = cmd_cnt;
    bstart;
    send_byte(8'b0111_001_0, 0, a);
    chk(!a, "R2 wrong code not acked", a, 0);
    send_byte(8'h55, 1, a);
    chk(!a && wr_cnt == w0 && cmd_cnt == c0, "R2 following byte ignored", wr_cnt - w0, 0);
    bstop;
  endtask

  task automatic t_time_write;
    bit a; int w0 = wr_cnt, r0 = rs_cnt, nak = 0, badd = 0;
    bstart;
    send_byte(hdr(3'd2, 0), 0, a);
    chk(a && hold_o, "R8 hold at command ack", hold_o, 1);
    for (int i = 0; i < 7; i++) begin
      send_byte(8'h11 * (i + 1), 1, a);
      if (!a) nak++;
      if (i == 5) chk(hold_o && rs_cnt == r0, "R8 hold kept mid burst", hold_o, 1);
    end
    chk(nak == 0, "R3 seven bytes acked", nak, 0);
    chk(!hold_o && rs_cnt == r0 + 1, "R8 release at final ack", rs_cnt - r0, 1);
    for (int i = 0; i < 7; i++)
      if (wr_log[(w0 + i) % 32] != 8'(8'h11 * (i + 1)) || wr_idx_log[(w0 + i) % 32] != 3'(i)) badd++;
    chk(badd == 0 && wr_cnt == w0 + 7, "R4 seven-byte burst data/index", wr_cnt - w0, 7);
    send_byte(8'h99, 1, a);
    chk(!a && wr_cnt == w0 + 7, "R4 eighth byte ignored", a, 0);
    bstop;
  endtask

  task automatic t_hms_abort;
    bit a; int r0 = rs_cnt;
    bstart;
    send_byte(hdr(3'd3, 0), 0, a);
    send_byte(8'h12, 1, a);
    chk(hold_o == 1, "R8 hold during 011 write", hold_o, 1);
    bstop;
    chk(!hold_o && rs_cnt == r0 + 1, "R9 stop releases hold", rs_cnt - r0, 1);
  endtask

  task automatic t_read_all;
    bit a; logic [7:0] v; int bad = 0, r0 = rd_cnt;
    bstart;
    send_byte(hdr(3'd2, 1), 0, a);
    chk(a, "R1 read header ack", a, 1);
    for (int i = 0; i < 7; i++) begin
      recv_byte(v, i < 6);
      if (v != {3'd2, 2'b10, 3'(i)}) bad++;
    end
    chk(bad == 0, "R5 read bytes LSB first", bad, 0);
    chk(rd_cnt == r0 + 7, "R5 read strobes", rd_cnt - r0, 7);
    tick(Q);
    chk(sda_oe_o == 0, "R6 released after nack", sda_oe_o, 0);
    bstop;
  endtask

  task automatic t_read_stop_abort;
    bit a; logic [7:0] v;
    bstart;
    send_byte(hdr(3'd3, 1), 0, a);
    recv_byte(v, 1);
    chk(v == 8'h70, "R5 first hms byte", v, 8'h70);
    bstop;
    chk(sda_oe_o == 0, "R6 stop aborts read", sda_oe_o, 0);
    bstart;
    send_byte(hdr(3'd1, 0), 0, a);
    chk(a, "R6 idle after abort accepts start", a, 1);
    bstop;
  endtask

  task automatic t_alarm_read;
    bit a; logic [7:0] v0, v1; int r0 = rd_cnt;
    bstart;
    send_byte(hdr(3'd4, 1), 0, a);
    chk(a, "R10 header acked", a, 1);
    recv_byte(v0, 1);
    recv_byte(v1, 0);
    chk(v0 == 8'hFF && v1 == 8'hFF && rd_cnt == r0, "R10 write-only read", {v0, v1}, 16'hFFFF);
    bstop;
  endtask

  task automatic t_alarm_write;
    bit a, a2, a3;
    bstart;
    send_byte(hdr(3'd5, 0), 0, a);
    send_byte(8'h01, 1, a);
    send_byte(8'h02, 1, a2);
    send_byte(8'h03, 1, a3);
    chk(a && a2 && !a3, "R4 two-byte alarm burst", {a, a2, a3}, 3'b110);
    bstop;
  endtask

  task automatic t_ctrl_cmds;
    bit a; logic [7:0] v; int w0 = wr_cnt, r0 = rd_cnt;
    bstart;
    send_byte(hdr(3'd0, 1), 0, a);
    chk(a && last_cmd == 3'd0, "R7 reset with R/W=1 accepted", last_cmd, 0);
    recv_byte(v, 0);
    chk(v == 8'hFF && rd_cnt == r0, "R7 reset moves no data", v, 8'hFF);
    bstop;
    bstart;
    send_byte(hdr(3'd6, 0), 0, a);
    chk(a && last_cmd == 3'd6, "R7 test-on accepted", last_cmd, 6);
    send_byte(8'h5A, 1, a);
    chk(!a && wr_cnt == w0, "R7 test-on no data", a, 0);
    bstop;
    bstart;
    send_byte(hdr(3'd7, 0), 0, a);
    chk(a && last_cmd == 3'd7, "R7 test-off accepted", last_cmd, 7);
    bstop;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset_state();
    t_status_write();
    t_bad_code();
    t_time_write();
    t_hms_abort();
    t_read_all();
    t_read_stop_abort();
    t_alarm_read();
    t_alarm_write();
    t_ctrl_cmds();
    done = 1;
    summary();
    $finish;
  end
endmodule